// File: doc/BRIEF.md
# Cascadable Pipelined Output Accumulator

This block is the output stage that sits behind the adder tree of a multi-tap FIR filter. It takes the full-precision tap sum (1 sign bit, 14 integer bits, 11 fraction bits), reduces it to a 20-bit pipeline word (1 sign bit, 13 integer bits, 6 fraction bits), and sends that word through an alignment delay. The delay length is chosen by a 2-bit select. The clear and invert controls travel through the same delay, so they act on the sum they were issued with.

At the end of the delay the word is cleared or negated as requested. It is then added to one of two operands. The first is the registered cascade input, which is used to join the partial sum of an upstream stage. The second is the block's own registered output, which is used to fold several partial sums of one filter together over successive cycles. The total is registered onto the 20-bit cascade output. That output can drive the cascade input of the next stage, so several stages can be chained with no extra logic between them.

Top module: `casc_out_accum`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the edge clears `chain_o` and all internal state to zero, regardless of the other inputs.
- R2: The wide sum is reduced by dropping its 5 lowest fraction bits with an arithmetic shift, which rounds toward minus infinity (-33 becomes -2, 100 becomes 3).
- R3: A reduced value above 524287 is clamped to 524287 (0x7FFFF), and a value below -524288 is clamped to -524288 (0x80000).
- R4: With `align_sel_i` = 00, 01, 10 or 11, a sum sampled at clock edge k first affects `chain_o` at edge k+1, k+3, k+4 or k+5 respectively.
- R5: `zero_n_i` is active low and forces its sum to contribute zero. It is delayed together with the sum it was sampled with.
- R6: `inv_i` is active high and negates its sum, and it is delayed together with that sum. When clear and invert are both active, clear wins. Negating -524288 gives 524287.
- R7: With `self_fb_i` low, the adder takes the cascade input as its second operand. A value on `chain_i` sampled at edge j is added at edge j+1.
- R8: With `self_fb_i` high, the adder takes the current `chain_o` as its second operand, so partial sums accumulate. The 20-bit sum wraps modulo 2^20 (0x7FFFF + 1 = 0x80000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fsum_i | input | 26 | Full-precision signed tap sum (11 fraction bits) |
| zero_n_i | input | 1 | Clear control for the sum, active low |
| inv_i | input | 1 | Negate control for the sum, active high |
| align_sel_i | input | 2 | Alignment delay select (1/3/4/5 cycles) |
| self_fb_i | input | 1 | Second adder operand: 0 selects the cascade input, 1 selects the own output |
| chain_i | input | 20 | Cascade input from an upstream stage |
| chain_o | output | 20 | Registered cascade output |

## Verification
The bench sends a single nonzero sum through a flushed pipe under each delay select and counts the edges until it appears. A wrong tap shows up as a latency count off by one or more. Directed values test rounding of negative values, both clamp limits, and the most-negative negation; cleared or inverted sums sent next to plain ones show whether the controls stay aligned with their sum. Random streams with mixed operand select, clear, invert and cascade values, for each delay setting, are checked cycle by cycle against a reference model. These streams separate the cascade operand's one-cycle lag from the feedback operand, and they also exercise the wrap at 2^20.

// File: rtl/casc_acc_pkg.sv
package casc_acc_pkg;

   typedef struct packed {
      logic keep_n;
      logic inv;
   } ctl_t;

   localparam ctl_t CTL_IDLE = '{keep_n: 1'b1, inv: 1'b0};

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/cao_trunc.sv
module cao_trunc #(
   parameter int unsigned IN_W     = 26,
   parameter int unsigned IN_FRAC  = 11,
   parameter int unsigned OUT_W    = 20,
   parameter int unsigned OUT_FRAC = 6
) (
   input  logic [IN_W-1:0]  wide_i,
   output logic [OUT_W-1:0] narrow_o
);
   localparam int unsigned SHIFT  = IN_FRAC - OUT_FRAC;
   localparam int unsigned KEEP_W = IN_W - SHIFT;

   logic [KEEP_W-1:0] kept;

   // dropping the low bits of a two's complement word rounds toward minus infinity
   generate
      if (SHIFT == 0) begin : g_nodrop
         assign kept = wide_i;
      end else begin : g_drop
         logic drop_unused;
         assign kept        = wide_i[IN_W-1:SHIFT];
         assign drop_unused = ^wide_i[SHIFT-1:0];
      end
   endgenerate

   generate
      if (KEEP_W > OUT_W) begin : g_sat
         localparam int unsigned XW = KEEP_W - OUT_W + 1;
         logic [XW-1:0] top;
         logic          fits;
         assign top  = kept[KEEP_W-1:OUT_W-1];
         assign fits = (top == '0) || (top == '1);
         always_comb begin
            if (fits)
               narrow_o = kept[OUT_W-1:0];
            else if (kept[KEEP_W-1])
               narrow_o = {1'b1, {(OUT_W-1){1'b0}}};
            else
               narrow_o = {1'b0, {(OUT_W-1){1'b1}}};
         end
      end else if (KEEP_W == OUT_W) begin : g_exact
         assign narrow_o = kept;
      end else begin : g_extend
         assign narrow_o = {{(OUT_W-KEEP_W){kept[KEEP_W-1]}}, kept};
      end
   endgenerate

endmodule

// File: rtl/cao_align.sv
module cao_align
   import casc_acc_pkg::*;
#(
   parameter int unsigned W    = 20,
   parameter int unsigned LAT0 = 1,
   parameter int unsigned LAT1 = 3,
   parameter int unsigned LAT2 = 4,
   parameter int unsigned LAT3 = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   sel_i,
   input  logic [W-1:0] sum_i,
   input  ctl_t         ctl_i,
   output logic [W-1:0] sum_o,
   output ctl_t         ctl_o
);
   localparam int unsigned DEPTH = max4(LAT0, LAT1, LAT2, LAT3);
   localparam int unsigned SW    = W + $bits(ctl_t);

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
         logic [SW-1:0] feed;
         logic [SW-1:0] q;
         if (s == 0) begin : g_head
            assign feed = {ctl_i, sum_i};
         end else begin : g_body
            assign feed = g_stage[s-1].q;
         end
         always_ff @(posedge clk) begin
            if (!rst_n) q <= {CTL_IDLE, {W{1'b0}}};
            else        q <= feed;
         end
      end
   endgenerate

   logic [SW-1:0] tap;

   always_comb begin
      case (sel_i)
         2'd0:    tap = g_stage[LAT0-1].q;
         2'd1:    tap = g_stage[LAT1-1].q;
         2'd2:    tap = g_stage[LAT2-1].q;
         default: tap = g_stage[LAT3-1].q;
      endcase
   end

   assign {ctl_o, sum_o} = tap;

endmodule

// File: rtl/cao_sign.sv
module cao_sign
   import casc_acc_pkg::*;
#(
   parameter int unsigned W = 20
) (
   input  logic [W-1:0] v_i,
   input  ctl_t         ctl_i,
   output logic [W-1:0] v_o
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

   always_comb begin
      if (!ctl_i.keep_n)
         v_o = '0;
      else if (ctl_i.inv)
         v_o = (v_i == MOST_NEG) ? MOST_POS : (~v_i + ONE);
      else
         v_o = v_i;
   end

endmodule

// File: rtl/cao_accum.sv
module cao_accum #(
   parameter int unsigned W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] term_i,
   input  logic         self_fb_i,
   input  logic [W-1:0] chain_i,
   output logic [W-1:0] chain_o
);
   logic [W-1:0] chain_q;
   logic [W-1:0] addend;
   logic [W-1:0] total;

   assign addend = self_fb_i ? chain_o : chain_q;
   assign total  = term_i + addend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         chain_o <= '0;
      end else begin
         chain_q <= chain_i;
         chain_o <= total;
      end
   end

endmodule

// File: rtl/casc_out_accum.sv
module casc_out_accum
   import casc_acc_pkg::*;
#(
   parameter int unsigned IN_W     = 26,
   parameter int unsigned IN_FRAC  = 11,
   parameter int unsigned OUT_W    = 20,
   parameter int unsigned OUT_FRAC = 6,
   parameter int unsigned LAT0     = 1,
   parameter int unsigned LAT1     = 3,
   parameter int unsigned LAT2     = 4,
   parameter int unsigned LAT3     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IN_W-1:0]  fsum_i,
   input  logic             zero_n_i,
   input  logic             inv_i,
   input  logic [1:0]       align_sel_i,
   input  logic             self_fb_i,
   input  logic [OUT_W-1:0] chain_i,
   output logic [OUT_W-1:0] chain_o
);
   generate
      if (IN_FRAC < OUT_FRAC) begin : g_bad_frac
         $error("casc_out_accum: output fraction wider than input fraction");
      end
      if (IN_W <= IN_FRAC - OUT_FRAC) begin : g_bad_width
         $error("casc_out_accum: input too narrow for the fraction drop");
      end
      if (OUT_W < 2) begin : g_bad_out
         $error("casc_out_accum: output must hold a sign and a magnitude bit");
      end
      if (LAT0 == 0 || LAT1 == 0 || LAT2 == 0 || LAT3 == 0) begin : g_bad_lat
         $error("casc_out_accum: every alignment delay must be at least one cycle");
      end
   endgenerate

   logic [OUT_W-1:0] narrow;
   logic [OUT_W-1:0] tail_sum;
   ctl_t             head_ctl;
   ctl_t             tail_ctl;
   logic [OUT_W-1:0] term;

   assign head_ctl = '{keep_n: zero_n_i, inv: inv_i};

   cao_trunc #(
      .IN_W(IN_W), .IN_FRAC(IN_FRAC), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)
   ) u_trunc (
      .wide_i   (fsum_i),
      .narrow_o (narrow)
   );

   cao_align #(
      .W(OUT_W), .LAT0(LAT0), .LAT1(LAT1), .LAT2(LAT2), .LAT3(LAT3)
   ) u_align (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_i (align_sel_i),
      .sum_i (narrow),
      .ctl_i (head_ctl),
      .sum_o (tail_sum),
      .ctl_o (tail_ctl)
   );

   cao_sign #(.W(OUT_W)) u_sign (
      .v_i   (tail_sum),
      .ctl_i (tail_ctl),
      .v_o   (term)
   );

   cao_accum #(.W(OUT_W)) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .term_i    (term),
      .self_fb_i (self_fb_i),
      .chain_i   (chain_i),
      .chain_o   (chain_o)
   );

endmodule

// File: rtl/casc_out_accum_chk.sv
module casc_out_accum_chk #(
   parameter int unsigned W = 20
) (
   input logic         clk,
   input logic         rst_n,
   input logic [1:0]   align_sel_i,
   input logic         self_fb_i,
   input logic [W-1:0] chain_i,
   input logic [W-1:0] chain_o,
   input logic [W-1:0] trunc_v,
   input logic [W-1:0] tail_v,
   input logic         tail_keep_n,
   input logic         tail_inv,
   input logic [W-1:0] term_v
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

   logic [1:0] age;

   always_ff @(posedge clk) begin
      if (!rst_n)          age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   // R4: the shortest setting hands the reduced word on after one edge
   p_align_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && align_sel_i == 2'd0) |-> (tail_v == $past(trunc_v)));

   // R5: a cleared sum leaves the sign stage as zero
   p_zero_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tail_keep_n |-> (term_v == '0));

   // R6: inversion yields the two's complement
   p_negate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_keep_n && tail_inv && tail_v != MOST_NEG) |-> (W'(term_v + tail_v) == '0));

   // R6: inverting the most negative word clamps
   p_neg_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_keep_n && tail_inv && tail_v == MOST_NEG) |-> (term_v == MOST_POS));

   // R7: cascade operand arrives one edge late
   p_cascade_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && !self_fb_i) |=> (chain_o == W'($past(term_v) + $past(chain_i, 2))));

   // R8: feeding back a zero term holds the output
   p_fb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (self_fb_i && term_v == '0) |=> $stable(chain_o));

endmodule

bind casc_out_accum casc_out_accum_chk #(.W(OUT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .align_sel_i (align_sel_i),
   .self_fb_i   (self_fb_i),
   .chain_i     (chain_i),
   .chain_o     (chain_o),
   .trunc_v     (narrow),
   .tail_v      (tail_sum),
   .tail_keep_n (tail_ctl.keep_n),
   .tail_inv    (tail_ctl.inv),
   .term_v      (term)
);

// File: tb/casc_out_accum_tb.sv
`timescale 1ns/1ps
module casc_out_accum_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [25:0] fsum = '0;
   logic        zero_n = 1'b1;
   logic        inv = 1'b0;
   logic [1:0]  align_sel = 2'd0;
   logic        self_fb = 1'b0;
   logic [19:0] chain_in = '0;
   logic [19:0] chain_out;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   logic [19:0] m_sum [5];
   logic        m_keep [5];
   logic        m_inv [5];
   logic [19:0] m_cin;
   logic [19:0] m_acc;

   always #2.5 clk = ~clk;

   casc_out_accum u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .fsum_i      (fsum),
      .zero_n_i    (zero_n),
      .inv_i       (inv),
      .align_sel_i (align_sel),
      .self_fb_i   (self_fb),
      .chain_i     (chain_in),
      .chain_o     (chain_out)
   );

   function automatic logic [19:0] f_reduce(input logic [25:0] w);
      int q;
      q = $signed(w) >>> 5;
      if (q > 524287)  q = 524287;
      if (q < -524288) q = -524288;
      return 20'(q);
   endfunction

   function automatic logic [19:0] f_apply(input logic [19:0] v, input logic kn, input logic iv);
      if (!kn) return 20'h0;
      if (iv) return (v == 20'h80000) ? 20'h7FFFF : 20'(-v);
      return v;
   endfunction

   function automatic int f_lat(input logic [1:0] s);
      case (s)
         2'd0: return 1;
         2'd1: return 3;
         2'd2: return 4;
         default: return 5;
      endcase
   endfunction

   task automatic chk(input logic [19:0] act, input logic [19:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [25:0] fs, input logic kn, input logic iv,
                       input logic fb, input logic [19:0] ch, input string tag);
      logic [19:0] t;
      fsum = fs; zero_n = kn; inv = iv; self_fb = fb; chain_in = ch;
      @(posedge clk);
      if (!rst_n) begin
         for (int i = 0; i < 5; i++) begin
            m_sum[i] = '0; m_keep[i] = 1'b1; m_inv[i] = 1'b0;
         end
         m_cin = '0; m_acc = '0;
      end else begin
         t = f_apply(m_sum[f_lat(align_sel)-1], m_keep[f_lat(align_sel)-1],
                     m_inv[f_lat(align_sel)-1]);
         m_acc = t + (fb ? m_acc : m_cin);
         for (int i = 4; i > 0; i--) begin
            m_sum[i] = m_sum[i-1]; m_keep[i] = m_keep[i-1]; m_inv[i] = m_inv[i-1];
         end
         m_sum[0] = f_reduce(fs); m_keep[0] = kn; m_inv[0] = iv;
         m_cin = ch;
      end
      @(negedge clk);
      chk(chain_out, m_acc, tag);
   endtask

   task automatic flush(input string tag);
      for (int i = 0; i < 6; i++) step('0, 1'b1, 1'b0, 1'b0, '0, tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      int lat;
      logic [22:0] x;
      logic [25:0] fs;
      seed = $urandom(32'd7731);
      for (int i = 0; i < 5; i++) begin
         m_sum[i] = '0; m_keep[i] = 1'b1; m_inv[i] = 1'b0;
      end
      m_cin = '0; m_acc = '0;
      @(negedge clk);

      // R1: reset with busy inputs
      rst_n = 1'b0;
      for (int i = 0; i < 4; i++) step(26'h0ABCDEF, 1'b1, 1'b0, 1'b1, 20'h5A5A5, "R1");
      chk(chain_out, 20'h0, "R1");
      rst_n = 1'b1;
      flush("R1");

      // R2: rounding toward minus infinity, delay 1
      align_sel = 2'd0;
      step(26'd100, 1'b1, 1'b0, 1'b0, '0, "R2");
      step('0, 1'b1, 1'b0, 1'b0, '0, "R2");
      chk(chain_out, 20'd3, "R2");
      step(-26'sd33, 1'b1, 1'b0, 1'b0, '0, "R2");
      step('0, 1'b1, 1'b0, 1'b0, '0, "R2");
      chk(chain_out, 20'hFFFFE, "R2");

      // R3: clamp at both limits
      step(26'h1FFFFFF, 1'b1, 1'b0, 1'b0, '0, "R3");
      step('0, 1'b1, 1'b0, 1'b0, '0, "R3");
      chk(chain_out, 20'h7FFFF, "R3");
      step(26'h2000000, 1'b1, 1'b0, 1'b0, '0, "R3");
      step('0, 1'b1, 1'b0, 1'b0, '0, "R3");
      chk(chain_out, 20'h80000, "R3");
      step(26'h0FFFFFF, 1'b1, 1'b0, 1'b0, '0, "R3");
      step('0, 1'b1, 1'b0, 1'b0, '0, "R3");
      chk(chain_out, 20'h7FFFF, "R3");

      // R4: impulse latency for each select
      for (int s = 0; s < 4; s++) begin
         align_sel = 2'(s);
         flush("R4");
         step(26'd160, 1'b1, 1'b0, 1'b0, '0, "R4");
         lat = 0;
         for (int n = 1; n <= 7; n++) begin
            step('0, 1'b1, 1'b0, 1'b0, '0, "R4");
            if (lat == 0 && chain_out == 20'd5) lat = n;
         end
         chk(20'(lat), 20'(f_lat(2'(s))), "R4");
      end

      // R5: clear travels with its sum, delay 3
      align_sel = 2'd1;
      flush("R5");
      step(26'd320, 1'b0, 1'b0, 1'b0, '0, "R5");
      step(26'd320, 1'b1, 1'b0, 1'b0, '0, "R5");
      step('0, 1'b1, 1'b0, 1'b0, '0, "R5");
      step('0, 1'b1, 1'b0, 1'b0, '0, "R5");
      chk(chain_out, 20'h0, "R5");
      step('0, 1'b1, 1'b0, 1'b0, '0, "R5");
      chk(chain_out, 20'd10, "R5");

      // R6: invert, priority, clamp, delay 1
      align_sel = 2'd0;
      flush("R6");
      step(26'd320, 1'b1, 1'b1, 1'b0, '0, "R6");
      step('0, 1'b1, 1'b0, 1'b0, '0, "R6");
      chk(chain_out, 20'hFFFF6, "R6");
      step(26'd320, 1'b0, 1'b1, 1'b0, '0, "R6");
      step('0, 1'b1, 1'b0, 1'b0, '0, "R6");
      chk(chain_out, 20'h0, "R6");
      step(26'h2000000, 1'b1, 1'b1, 1'b0, '0, "R6");
      step('0, 1'b1, 1'b0, 1'b0, '0, "R6");
      chk(chain_out, 20'h7FFFF, "R6");

      // R7: cascade operand one edge late
      flush("R7");
      step('0, 1'b1, 1'b0, 1'b0, 20'h12345, "R7");
      chk(chain_out, 20'h0, "R7");
      step(26'd320, 1'b1, 1'b0, 1'b0, 20'h00100, "R7");
      chk(chain_out, 20'h12345, "R7");
      step('0, 1'b1, 1'b0, 1'b0, '0, "R7");
      chk(chain_out, 20'h0010A, "R7");

      // R8: accumulation and wrap
      flush("R8");
      for (int i = 0; i < 3; i++) step(26'd320, 1'b1, 1'b0, 1'b1, 20'hFFFFF, "R8");
      step('0, 1'b1, 1'b0, 1'b1, 20'hFFFFF, "R8");
      chk(chain_out, 20'd30, "R8");
      flush("R8");
      step('0, 1'b1, 1'b0, 1'b0, 20'h7FFFF, "R8");
      step(26'd32, 1'b1, 1'b0, 1'b0, '0, "R8");
      step('0, 1'b1, 1'b0, 1'b1, '0, "R8");
      chk(chain_out, 20'h80000, "R8");

      // random streams for every delay setting
      for (int s = 0; s < 4; s++) begin
         align_sel = 2'(s);
         for (int i = 0; i < 250; i++) begin
            logic kn, iv, fb;
            x = 23'($urandom);
            if ($urandom % 4 == 0) fs = 26'($urandom);
            else fs = {{3{x[22]}}, x};
            kn = ($urandom % 8) != 0;
            iv = 1'($urandom);
            fb = 1'($urandom);
            step(fs, kn, iv, fb, 20'($urandom), fb ? "R8" : "R7");
         end
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule